// File: doc/BRIEF.md
# Flash word-program controller

This block is the control logic of a small NOR-style flash array. It sits on a simple bus with separate write and read strobes. It watches the write strobes for a four-step program command. On the last step it captures a target word and its data. It then runs an automatic programming operation that takes a fixed number of clocks. While the operation runs, any read returns a status word instead of array contents. The status word carries three flags: an inverted-data polling bit, a toggle bit, and a time-limit bit.

The array behaves like flash cells. Programming can only turn stored 1 bits into 0 bits. A request that needs a 0 to become 1 never completes. After a time limit it parks the block in a fault state, which reports status until software writes a clear code.

A full-array erase input returns every word to all ones. The array is a register file of `DEPTH` 16-bit words, selected by the low bits of the word address. Upper address bits alias, so programming works across any sector layout and in any order.

Top module: `nor_prog_ctrl`

## Requirements
- R1: A program operation starts only after four consecutive writes. The word address is `bus_addr[AW-1:1]`. The steps are: low byte 0xAA to word address 0x555, then low byte 0x55 to word address 0x2AA, then low byte 0xA0 to word address 0x555, then the target write. Any write that does not match the expected step returns the block to read mode without programming.
- R2: If the target write has `bus_addr[0]` = 1, the command is dropped. No word changes and the block is back in read mode.
- R3: One command changes exactly one word: the word at index `bus_addr[IDX_W:1]`. Targets may come in any order and with any upper address bits. For a request that can complete, the stored word becomes old AND data. The block is back in read mode `PROG_CYCLES` clocks after the target write. In read mode, a read returns array contents on `bus_rdata` one clock after `bus_re`.
- R4: While the operation runs, a read at any address returns a status word with these fields: bit 7 is the inverse of target data bit 7, bit 5 is 0, and bits 15:8 and 4:0 are 0.
- R5: Status bit 6 reads 0 on the first status read of an operation. It inverts after every status read while the operation runs.
- R6: If the data has a 1 where the stored word has a 0, the operation does not complete. After `TLIM_CYCLES` clocks the block enters a fault state with the array unchanged. In the fault state, reads return bit 5 = 1, bit 7 = the true target data bit 7, and bit 6 held at its last value.
- R7: Every bus write is ignored while the operation runs, including the clear code and new command sequences.
- R8: In the fault state, a write whose low byte is 0xF0 returns the block to read mode. Every other write is ignored.
- R9: An asynchronous hardware reset (`rst_n` low) returns the block to read mode and clears `bus_rdata` to 0. A word whose programming was interrupted keeps its previous contents.
- R10: `erase_all` high at a clock edge sets every word to 0xFFFF, unless an operation is running or the block is in the fault state; in those two states it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_all | input | 1 | Set every word to all ones (read-side states only) |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data or status word |

## Verification
The bound checker watches every cycle for the following:
- an operation that starts from any step other than a completed three-write unlock, or from an odd target address;
- a captured target that changes while busy;
- a status read while busy whose polling or time-limit bit is wrong;
- a toggle bit that fails to flip while busy or moves while faulted;
- a fault-state write without the clear code that leaves the fault state.

Some behaviours need stored contents, so only the bench scenarios can show them:
- the exact clock on which array data returns;
- that only the addressed word changes across a full sweep of indices and upper address bits;
- that a timed-out, interrupted or odd-address request leaves the array untouched;
- that erase has no effect while busy.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

  localparam int WORD_W = 16;
  localparam int CODE_W = 8;
  localparam int KEY_AW = 12;

  localparam logic [CODE_W-1:0] CODE_KEY1 = 8'hAA;
  localparam logic [CODE_W-1:0] CODE_KEY2 = 8'h55;
  localparam logic [CODE_W-1:0] CODE_PGM  = 8'hA0;
  localparam logic [CODE_W-1:0] CODE_CLR  = 8'hF0;

  localparam logic [KEY_AW-1:0] KEY_ADDR_A = 12'h555;
  localparam logic [KEY_AW-1:0] KEY_ADDR_B = 12'h2AA;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int TLIM_BIT = 5;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_UNL1  = 3'd1,
    ST_UNL2  = 3'd2,
    ST_ARMED = 3'd3,
    ST_BUSY  = 3'd4,
    ST_FAULT = 3'd5
  } ctl_state_e;

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_prog_pkg::*;
#(
  parameter int AW    = 13,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  word_t            bus_wdata,
  input  logic             op_done,
  input  logic             op_fail,
  output ctl_state_e       state_o,
  output logic             start_o,
  output logic [IDX_W-1:0] tgt_idx_o,
  output word_t            tgt_data_o
);

  localparam int WA_W = AW - 1;

  logic [WA_W-1:0]   wr_waddr;
  logic [CODE_W-1:0] wr_code;
  logic              at_key_a;
  logic              at_key_b;
  logic              odd_byte;

  ctl_state_e        state_q;
  ctl_state_e        state_d;
  logic              start;
  logic [IDX_W-1:0]  tgt_idx_q;
  word_t             tgt_data_q;

  assign wr_waddr = bus_addr[AW-1:1];
  assign odd_byte = bus_addr[0];
  assign wr_code  = bus_wdata[CODE_W-1:0];
  assign at_key_a = (wr_waddr == WA_W'(KEY_ADDR_A));
  assign at_key_b = (wr_waddr == WA_W'(KEY_ADDR_B));

  // next-state decode
  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    unique case (state_q)
      ST_READ: begin
        if (bus_we && at_key_a && (wr_code == CODE_KEY1)) state_d = ST_UNL1;
      end
      ST_UNL1: begin
        if (bus_we) begin
          state_d = (at_key_b && (wr_code == CODE_KEY2)) ? ST_UNL2 : ST_READ;
        end
      end
      ST_UNL2: begin
        if (bus_we) begin
          state_d = (at_key_a && (wr_code == CODE_PGM)) ? ST_ARMED : ST_READ;
        end
      end
      ST_ARMED: begin
        if (bus_we) begin
          if (!odd_byte) begin
            state_d = ST_BUSY;
            start   = 1'b1;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_BUSY: begin
        if (op_done)      state_d = ST_READ;
        else if (op_fail) state_d = ST_FAULT;
      end
      ST_FAULT: begin
        if (bus_we && (wr_code == CODE_CLR)) state_d = ST_READ;
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_READ;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_idx_q  <= '0;
      tgt_data_q <= '0;
    end else if (start) begin
      tgt_idx_q  <= wr_waddr[IDX_W-1:0];
      tgt_data_q <= bus_wdata;
    end
  end

  assign state_o    = state_q;
  assign start_o    = start;
  assign tgt_idx_o  = tgt_idx_q;
  assign tgt_data_o = tgt_data_q;

endmodule

// File: rtl/nor_prog_timer.sv
module nor_prog_timer
  import nor_prog_pkg::*;
#(
  parameter int PROG_CYCLES = 8,
  parameter int TLIM_CYCLES = 40
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  busy,
  input  logic  stat_rd,
  input  word_t old_word,
  input  word_t new_data,
  output logic  done_o,
  output logic  fail_o,
  output logic  tog_o
);

  localparam int CNT_W = $clog2(TLIM_CYCLES + 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] TLIM_LAST = CNT_W'(TLIM_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             tog_q;
  logic             tog_d;
  logic             tog_en;
  logic             blocked;

  // a 1 requested over a stored 0 can never be reached
  assign blocked = |(~old_word & new_data);

  always_comb begin
    cnt_en = start | busy;
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    tog_en = start | (busy & stat_rd);
    tog_d  = start ? 1'b0 : ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

  assign done_o = busy & ~blocked & (cnt_q == PROG_LAST);
  assign fail_o = busy &  blocked & (cnt_q == TLIM_LAST);
  assign tog_o  = tog_q;

endmodule

// File: rtl/nor_word_array.sv
module nor_word_array
  import nor_prog_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             erase,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_data,
  input  logic [IDX_W-1:0] rda_idx,
  output word_t            rda_data,
  input  logic [IDX_W-1:0] rdb_idx,
  output word_t            rdb_data
);

  logic [DEPTH*WORD_W-1:0] flat;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    word_t cell_q;
    word_t cell_d;
    logic  cell_en;

    always_comb begin
      cell_en = erase | (wr_en && (wr_idx == IDX_W'(gi)));
      cell_d  = erase ? '1 : (cell_q & wr_data);
    end

    always_ff @(posedge clk) begin
      if (cell_en) cell_q <= cell_d;
    end

    assign flat[gi*WORD_W +: WORD_W] = cell_q;
  end

  assign rda_data = flat[rda_idx*WORD_W +: WORD_W];
  assign rdb_data = flat[rdb_idx*WORD_W +: WORD_W];

endmodule

// File: rtl/nor_prog_ctrl.sv
module nor_prog_ctrl
  import nor_prog_pkg::*;
#(
  parameter int AW          = 13,
  parameter int DEPTH       = 32,
  parameter int PROG_CYCLES = 8,
  parameter int TLIM_CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_all,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata
);

  localparam int IDX_W = $clog2(DEPTH);

  ctl_state_e       ctl_state;
  logic             prog_start;
  logic             prog_done;
  logic             prog_fail;
  logic             tog_bit;
  logic [IDX_W-1:0] tgt_idx;
  word_t            tgt_data;
  word_t            old_word;
  word_t            arr_word;
  word_t            stat_word;
  logic             busy;
  logic             faulted;
  logic             erase_ok;
  word_t            rdata_q;
  word_t            rdata_d;

  assign busy     = (ctl_state == ST_BUSY);
  assign faulted  = (ctl_state == ST_FAULT);
  assign erase_ok = erase_all & ~busy & ~faulted;

  nor_cmd_fsm #(
    .AW    (AW),
    .IDX_W (IDX_W)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .op_done    (prog_done),
    .op_fail    (prog_fail),
    .state_o    (ctl_state),
    .start_o    (prog_start),
    .tgt_idx_o  (tgt_idx),
    .tgt_data_o (tgt_data)
  );

  nor_prog_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .TLIM_CYCLES (TLIM_CYCLES)
  ) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (prog_start),
    .busy     (busy),
    .stat_rd  (bus_re),
    .old_word (old_word),
    .new_data (tgt_data),
    .done_o   (prog_done),
    .fail_o   (prog_fail),
    .tog_o    (tog_bit)
  );

  nor_word_array #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) arr_i (
    .clk      (clk),
    .erase    (erase_ok),
    .wr_en    (prog_done),
    .wr_idx   (tgt_idx),
    .wr_data  (tgt_data),
    .rda_idx  (bus_addr[IDX_W:1]),
    .rda_data (arr_word),
    .rdb_idx  (tgt_idx),
    .rdb_data (old_word)
  );

  // status word: polling bit true only once faulted
  always_comb begin
    stat_word           = '0;
    stat_word[POLL_BIT] = faulted ? tgt_data[POLL_BIT] : ~tgt_data[POLL_BIT];
    stat_word[TOG_BIT]  = tog_bit;
    stat_word[TLIM_BIT] = faulted;
  end

  assign rdata_d = (busy || faulted) ? stat_word : arr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/nor_prog_ctrl_chk.sv
module nor_prog_ctrl_chk
  import nor_prog_pkg::*;
#(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_re,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   bus_rdata,
  input ctl_state_e    state,
  input logic          start,
  input logic          done,
  input logic          fail,
  input logic          tog,
  input word_t         tgt_data
);

  AST_START_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state == ST_ARMED) && bus_we) else $error("start outside armed"); // R1

  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED) && bus_we && !start |=> (state == ST_READ)) else $error("bad entry"); // R1

  AST_START_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !bus_addr[0]) else $error("odd start"); // R2

  AST_DONE_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state == ST_READ)) else $error("done not read"); // R3

  AST_POLL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && (state == ST_BUSY) |=>
      (bus_rdata[POLL_BIT] == ~tgt_data[POLL_BIT]) && !bus_rdata[TLIM_BIT]) else $error("poll"); // R4

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && (state == ST_BUSY) |=> tog != $past(tog)) else $error("toggle"); // R5

  AST_FAIL_TO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> (state == ST_FAULT)) else $error("fail not fault"); // R6

  AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT) |=> $stable(tog)) else $error("toggle moved"); // R6

  AST_FAULT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && (state == ST_FAULT) |=>
      bus_rdata[TLIM_BIT] && (bus_rdata[POLL_BIT] == tgt_data[POLL_BIT])) else $error("fault st"); // R6

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |=> $stable(tgt_data)) else $error("target moved"); // R7

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT) && !(bus_we && (bus_wdata[CODE_W-1:0] == CODE_CLR)) |=>
      (state == ST_FAULT)) else $error("fault left"); // R8

endmodule

bind nor_prog_ctrl nor_prog_ctrl_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_re    (bus_re),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .state     (ctl_state),
  .start     (prog_start),
  .done      (prog_done),
  .fail      (prog_fail),
  .tog       (tog_bit),
  .tgt_data  (tgt_data)
);

// File: tb/nor_prog_ctrl_tb_top.sv
module nor_prog_ctrl_tb_top;

  localparam int AW = 13;
  localparam int DEPTH = 16;
  localparam int PC = 5;
  localparam int TL = 12;

  logic        clk;
  logic        rst_n;
  logic        erase_all;
  logic        bus_we;
  logic        bus_re;
  logic [12:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  logic [15:0] mdl [DEPTH];
  int n_chk;
  int n_bad;

  nor_prog_ctrl #(
    .AW(AW), .DEPTH(DEPTH), .PROG_CYCLES(PC), .TLIM_CYCLES(TL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .erase_all(erase_all), .bus_we(bus_we),
    .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stat_exp(input logic [15:0] d, input logic t, input logic flt);
    logic [15:0] s;
    s = '0;
    s[7] = flt ? d[7] : ~d[7];
    s[6] = t;
    s[5] = flt;
    return s;
  endfunction

  function automatic logic [12:0] baddr(input int hi, input int idx);
    logic [7:0] h;
    logic [3:0] w;
    h = hi[7:0];
    w = idx[3:0];
    return {h, w, 1'b0};
  endfunction

  // all tasks start and end at a falling edge
  task automatic idle();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [15:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic issue(input logic [12:0] tgt, input logic [15:0] d);
    bus_write(13'hAAA, 16'h00AA);
    bus_write(13'h554, 16'h0055);
    bus_write(13'hAAA, 16'h00A0);
    bus_write(tgt, d);
  endtask

  task automatic poll_ok(input logic [12:0] tgt, input int idx, input logic [15:0] d);
    logic [15:0] got;
    logic t;
    t = 1'b0;
    for (int j = 0; j < PC; j++) begin
      bus_read(baddr(j * 3, j), got);
      check("R4 R5 busy status", got, stat_exp(d, t, 1'b0));
      t = ~t;
    end
    mdl[idx] = mdl[idx] & d;
    bus_read(tgt, got);
    check("R3 word after completion", got, mdl[idx]);
  endtask

  task automatic pulse_reset();
    rst_n = 1'b0;
    idle(); idle();
    rst_n = 1'b1;
    idle();
  endtask

  initial begin : watchdog
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] got;
    logic [15:0] d;
    logic t;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; erase_all = 1'b0; bus_we = 1'b0; bus_re = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    idle(); idle();
    rst_n = 1'b1;
    idle();
    check("R9 rdata after reset", bus_rdata, 16'h0000);

    // R10 erase in read mode
    erase_all = 1'b1; idle(); erase_all = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      mdl[i] = 16'hFFFF;
      bus_read(baddr(i + 40, i), got);
      check("R10 erased word", got, 16'hFFFF);
    end

    // R3 sweep: scrambled order, varied upper address bits
    for (int i = 0; i < DEPTH; i++) begin
      int idx;
      idx = (i * 7 + 3) % DEPTH;
      d = 16'h5A3C ^ (16'(i) * 16'h1111);
      issue(baddr(i * 13, idx), d);
      poll_ok(baddr(i * 13, idx), idx, d);
    end
    // second pass clears further bits only
    for (int i = 0; i < DEPTH; i++) begin
      int idx;
      idx = (DEPTH - 1 - i);
      d = mdl[idx] & ~(16'h0081 << (i % 8));
      issue(baddr(200 - i, idx), d);
      poll_ok(baddr(200 - i, idx), idx, d);
    end
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(baddr(i, i), got);
      check("R3 one word per command", got, mdl[i]);
    end

    // R1 broken sequences
    d = mdl[1] & 16'h00FF;
    bus_write(13'hAA8, 16'h00AA);
    bus_write(13'h554, 16'h0055);
    bus_write(13'hAAA, 16'h00A0);
    bus_write(baddr(0, 1), d);
    bus_read(baddr(0, 1), got);
    check("R1 wrong first address", got, mdl[1]);
    bus_write(13'hAAA, 16'h00AA);
    bus_write(13'h556, 16'h0055);
    bus_write(13'hAAA, 16'h00A0);
    bus_write(baddr(0, 1), d);
    bus_read(baddr(0, 1), got);
    check("R1 wrong second address", got, mdl[1]);
    bus_write(13'hAAA, 16'h00AA);
    bus_write(13'h554, 16'h0055);
    bus_write(13'hAAA, 16'h0080);
    bus_write(baddr(0, 1), d);
    bus_read(baddr(0, 1), got);
    check("R1 wrong command code", got, mdl[1]);

    // R2 odd target
    issue(baddr(0, 1) | 13'h1, d);
    bus_read(baddr(0, 1), got);
    check("R2 odd target dropped", got, mdl[1]);
    bus_read(baddr(0, 0), got);
    check("R2 neighbour untouched", got, mdl[0]);

    // R6 timeout while reading every cycle
    d = 16'hFFFF;
    issue(baddr(7, 2), d);
    t = 1'b0;
    for (int j = 0; j < TL; j++) begin
      bus_read(baddr(7, 2), got);
      check("R5 busy toggle before timeout", got, stat_exp(d, t, 1'b0));
      t = ~t;
    end
    for (int j = 0; j < 3; j++) begin
      bus_read(baddr(j, j), got);
      check("R6 fault status frozen", got, stat_exp(d, t, 1'b1));
    end
    // R8 non-clear write ignored
    bus_write(13'hAAA, 16'h00AA);
    bus_read(baddr(7, 2), got);
    check("R8 fault kept", got, stat_exp(d, t, 1'b1));
    bus_write(baddr(3, 3), 16'h12F0);
    bus_read(baddr(7, 2), got);
    check("R6 R8 array unchanged after clear", got, mdl[2]);

    // R6 timeout with few reads: toggle frozen at 1, bit 7 clear
    d = 16'hFF7F;
    issue(baddr(9, 5), d);
    bus_read(baddr(9, 5), got);
    check("R5 first read zero", got, stat_exp(d, 1'b0, 1'b0));
    bus_read(baddr(9, 5), got);
    check("R5 second read one", got, stat_exp(d, 1'b1, 1'b0));
    bus_read(baddr(9, 5), got);
    for (int j = 0; j < TL; j++) idle();
    bus_read(baddr(9, 5), got);
    check("R6 fault polling true bit", got, stat_exp(d, 1'b1, 1'b1));
    bus_write(baddr(0, 0), 16'h00F0);
    bus_read(baddr(9, 5), got);
    check("R6 word kept after timeout", got, mdl[5]);

    // R7 writes during busy
    d = mdl[9] & 16'hF0F0;
    issue(baddr(1, 9), d);
    bus_write(13'hAAA, 16'h00AA);
    bus_write(13'h554, 16'h0055);
    bus_write(13'hAAA, 16'h00A0);
    bus_write(baddr(1, 11), 16'h0000);
    bus_write(13'hAAA, 16'h00F0);
    mdl[9] = mdl[9] & d;
    bus_read(baddr(1, 9), got);
    check("R7 target done despite writes", got, mdl[9]);
    bus_read(baddr(1, 11), got);
    check("R7 second target untouched", got, mdl[11]);

    // R10 erase ignored while busy
    d = mdl[4] & 16'h0FF0;
    issue(baddr(2, 4), d);
    erase_all = 1'b1; idle(); idle(); erase_all = 1'b0;
    for (int j = 0; j < PC; j++) idle();
    mdl[4] = mdl[4] & d;
    bus_read(baddr(2, 4), got);
    check("R10 busy erase ignored target", got, mdl[4]);
    bus_read(baddr(2, 0), got);
    check("R10 busy erase ignored other", got, mdl[0]);

    // R9 reset mid operation
    issue(baddr(4, 6), 16'h0000);
    idle();
    pulse_reset();
    check("R9 rdata cleared", bus_rdata, 16'h0000);
    bus_read(baddr(4, 6), got);
    check("R9 interrupted word kept", got, mdl[6]);
    d = mdl[6] & 16'h3333;
    issue(baddr(4, 6), d);
    poll_ok(baddr(4, 6), 6, d);

    // R10 final erase and sweep
    erase_all = 1'b1; idle(); erase_all = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(baddr(i * 5, i), got);
      check("R10 erase after programming", got, 16'hFFFF);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule